// File: doc/BRIEF.md
# Command decoder with transfer counter

This block sits behind the register port of a small bus-initiator controller. It watches byte writes to the command register, splits each written byte into a DMA flag and a seven-bit opcode, and keeps the transfer counter that the command stream loads and consumes. For every opcode it produces the resulting status, interrupt-cause, sequence-step and FIFO-flag values, plus one-cycle pulses that tell the neighbouring units what to do: request a DMA burst, start a target selection, issue a captured command, reset the bus or the chip, or raise an interrupt.

The counter can be written in bytes at any time. A DMA command copies the written value into the readable counter. A transfer-information command turns the readable value into an effective burst length. In that conversion zero stands for the full counter range. The length is then limited either by the data still owed by the target or, during command capture, by a fixed command-buffer size. Selection commands are held back while the DMA-enable input is low and run on its next rising edge. The target is taken from the bus-ID register.

Top module: `xfer_cmd_decoder`

## Requirements
- R1: A command byte is split into bit 7 (DMA flag, shown on `dma_mode`) and bits 6:0 (opcode); a command with bit 7 set copies the last written counter bytes into `count_q`, one with bit 7 clear leaves `count_q` alone.
- R2: A write to a counter byte (address 0 holds bits 7:0, address 1 holds bits 15:8 when present) clears status bit 4 and does not change `count_q`.
- R3: Opcode 0x10 with the DMA flag clears status bit 4 and computes the length as the smaller of the counter (0 read as 2^CNT_W) and `xfer_rem`. If that length is non-zero, `dma_req` pulses for one cycle carrying that length and with `dma_to_dev` equal to `xfer_out`.
- R4: In command-capture mode the same length is limited to CMD_LIMIT instead of `xfer_rem`, and `dma_to_dev` is 1.
- R5: `dma_done` outside capture sets status bit 4, sets cause to 0x10, sets sequence step and flags to 0, zeroes `count_q` and pulses `irq_set`.
- R6: Flush (0x01) sets cause to 0x08 and zeroes the sequence step and flags. Pad (0x18) sets status to 0x10, cause to 0x08 and the sequence step to 0. Enable-selection (0x44) sets cause to 0. No-op (0x00) and set-ATN (0x1A) change nothing. None of these pulse `irq_set`.
- R7: Message-accepted (0x12) sets cause to 0x20, zeroes the sequence step and flags and pulses `irq_set`. Bus reset (0x03) sets cause to 0x80, pulses `bus_rst`, and pulses `irq_set` only when `busrst_quiet` is 0.
- R8: Completion sequence (0x11) sets cause to 0x08 and pulses `irq_set`. With the DMA flag it sets status to 0x17 and the sequence step to 4. Without the flag it ORs 0x07 into the status and sets the flags to 2.
- R9: Selection uses bits ID_W-1:0 of the register at address 4 as the target. If that target's `tgt_present` bit is 0, status becomes 0, cause 0x20, the sequence step 0, and `irq_set` pulses. Otherwise 0x41 and 0x42 pulse `sel_go` with `sel_tgt`, and `sel_atn` is 1 only for 0x42.
- R10: Opcode 0x43 on a present target enters command capture, sets status to 0x12, cause to 0x18 and the sequence step to 4, and pulses `irq_set`.
- R11: A selection written while `dma_en` is 0 does nothing until `dma_en` rises. It then runs using the bus ID held at that time.
- R12: In capture, a non-DMA 0x10 or a `dma_done` pulses `cmd_issue` and leaves capture without changing the status.
- R13: Chip reset (0x02) returns every register of the block to its reset value (all zero) and pulses `chip_rst`.
- R14: An undefined opcode pulses `bad_op` and changes no state other than the DMA-flag effects of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register index |
| wr_data | input | 8 | Register write byte |
| dma_en | input | 1 | DMA enable from the channel; gates selections |
| tgt_present | input | 2**ID_W | One bit per target ID, 1 when the target answers |
| xfer_rem | input | CNT_W+1 | Magnitude of data still owed by the target |
| xfer_out | input | 1 | 1 when the pending data phase goes to the device |
| dma_done | input | 1 | Burst finished pulse from the DMA engine |
| busrst_quiet | input | 1 | Suppress the interrupt of a bus reset |
| count_q | output | CNT_W | Readable transfer counter |
| status_q | output | 8 | Status value for the status unit |
| cause_q | output | 8 | Interrupt cause value |
| seq_q | output | 3 | Sequence step |
| flags_q | output | 5 | FIFO flag count |
| irq_set | output | 1 | Raise-interrupt pulse |
| dma_mode | output | 1 | DMA flag of the last command |
| dma_req | output | 1 | Burst request pulse |
| dma_len | output | CNT_W+1 | Burst length with the request |
| dma_to_dev | output | 1 | Burst direction, 1 = memory to device |
| cmd_capture | output | 1 | Command-capture mode |
| cmd_issue | output | 1 | Captured command is complete |
| sel_go | output | 1 | Start selection pulse |
| sel_atn | output | 1 | Selection asserts attention |
| sel_tgt | output | ID_W | Selected target |
| chip_rst | output | 1 | Chip reset pulse |
| bus_rst | output | 1 | Bus reset pulse |
| bad_op | output | 1 | Undefined opcode pulse |

## Verification
The bench builds the block with CNT_W = 8, so the counter is a single byte and the zero-means-full case stands for 256. At that size every counter value can be swept against several remaining-data values, both in the normal data phase and in capture mode where CMD_LIMIT = 32 takes over. ID_W stays 3, so the sweep covers all eight targets against a mixed presence mask, and all 115 undefined opcodes can be issued one after another.

// File: rtl/cdx_pkg.sv
package cdx_pkg;

   typedef enum logic [6:0] {
      OP_NOP     = 7'h00,
      OP_FLUSH   = 7'h01,
      OP_CHIPRST = 7'h02,
      OP_BUSRST  = 7'h03,
      OP_XFER    = 7'h10,
      OP_CMPLT   = 7'h11,
      OP_MSGOK   = 7'h12,
      OP_PAD     = 7'h18,
      OP_ATN     = 7'h1A,
      OP_SEL     = 7'h41,
      OP_SELA    = 7'h42,
      OP_SELAS   = 7'h43,
      OP_ARM     = 7'h44
   } op_e;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_PLAIN = 2'd1,
      SEL_ATN   = 2'd2,
      SEL_STOP  = 2'd3
   } sel_e;

   localparam logic [7:0] ST_TC    = 8'h10;
   localparam logic [7:0] ST_CMDPH = 8'h02;
   localparam logic [7:0] ST_STSPH = 8'h03;
   localparam logic [7:0] ST_MSGIN = 8'h07;

   localparam logic [7:0] CA_FC   = 8'h08;
   localparam logic [7:0] CA_BS   = 8'h10;
   localparam logic [7:0] CA_DC   = 8'h20;
   localparam logic [7:0] CA_BRST = 8'h80;

   localparam logic [2:0] SEQ_CMD = 3'd4;

   function automatic logic op_known(input logic [6:0] op);
      case (op)
         OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_CMPLT,
         OP_MSGOK, OP_PAD, OP_ATN, OP_SEL, OP_SELA, OP_SELAS, OP_ARM:
            op_known = 1'b1;
         default: op_known = 1'b0;
      endcase
   endfunction

   function automatic sel_e sel_kind(input logic [6:0] op);
      case (op)
         OP_SEL:   sel_kind = SEL_PLAIN;
         OP_SELA:  sel_kind = SEL_ATN;
         OP_SELAS: sel_kind = SEL_STOP;
         default:  sel_kind = SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cdx_xfer_count.sv
module cdx_xfer_count #(
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 4,
   parameter int CMD_LIMIT = 32,
   parameter bit ZERO_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              reload,
   input  logic              wipe,
   input  logic              drain,
   input  logic              capture,
   input  logic [CNT_W:0]    rem,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W:0]    len,
   output logic              hit
);

   localparam int NBYTES = CNT_W / 8;
   localparam logic [CNT_W:0] CMD_CAP = (CNT_W+1)'(CMD_LIMIT);

   if (CNT_W % 8 != 0 || CNT_W < 8 || CNT_W > 16) begin : g_bad_width
      $error("cdx_xfer_count: CNT_W must be 8 or 16");
   end
   if (CMD_LIMIT < 1 || CMD_LIMIT > (1 << CNT_W)) begin : g_bad_limit
      $error("cdx_xfer_count: CMD_LIMIT out of range");
   end

   logic [CNT_W-1:0]  wcnt;
   logic [NBYTES-1:0] hit_b;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic [7:0] byte_q;
      assign hit_b[b] = wr_en && (wr_addr == ADDR_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        byte_q <= '0;
         else if (wipe)     byte_q <= '0;
         else if (hit_b[b]) byte_q <= wr_data;
      end
      assign wcnt[8*b +: 8] = byte_q;
   end

   assign hit = |hit_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (wipe || drain) cnt_q <= '0;
      else if (reload)        cnt_q <= wcnt;
   end

   logic [CNT_W-1:0] src;
   logic [CNT_W:0]   eff, lim;

   assign src = reload ? wcnt : cnt_q;

   if (ZERO_FULL) begin : g_zero_full
      assign eff = (src == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, src};
   end else begin : g_zero_plain
      assign eff = {1'b0, src};
   end

   assign lim = capture ? CMD_CAP : rem;
   assign len = (eff < lim) ? eff : lim;

   // R2
   no_reload_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wipe && !drain) |=> $stable(cnt_q));

   // R4
   cap_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> len <= CMD_CAP);

endmodule

// File: rtl/cdx_sel_gate.sv
module cdx_sel_gate
   import cdx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  sel_e req_kind,
   input  logic dma_en,
   input  logic wipe,
   output logic fire,
   output sel_e fire_kind
);

   logic pend_q;
   sel_e kind_q;
   logic en_q;
   logic rise;

   assign rise      = dma_en && !en_q;
   assign fire      = (req && dma_en) || (pend_q && rise && !req);
   assign fire_kind = req ? req_kind : kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         kind_q <= SEL_NONE;
         en_q   <= 1'b0;
      end else begin
         en_q <= dma_en;
         if (wipe) begin
            pend_q <= 1'b0;
            kind_q <= SEL_NONE;
         end else if (req && !dma_en) begin
            pend_q <= 1'b1;
            kind_q <= req_kind;
         end else if (fire) begin
            pend_q <= 1'b0;
         end
      end
   end

   // R11
   fire_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> dma_en);

   // R11
   hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !dma_en && !wipe) |=> pend_q);

endmodule

// File: rtl/xfer_cmd_decoder.sv
module xfer_cmd_decoder
   import cdx_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 4,
   parameter int ID_W      = 3,
   parameter int CMD_LIMIT = 32,
   parameter int CMD_ADDR  = 3,
   parameter int ID_ADDR   = 4,
   parameter bit ZERO_FULL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                dma_en,
   input  logic [2**ID_W-1:0]  tgt_present,
   input  logic [CNT_W:0]      xfer_rem,
   input  logic                xfer_out,
   input  logic                dma_done,
   input  logic                busrst_quiet,
   output logic [CNT_W-1:0]    count_q,
   output logic [7:0]          status_q,
   output logic [7:0]          cause_q,
   output logic [2:0]          seq_q,
   output logic [4:0]          flags_q,
   output logic                irq_set,
   output logic                dma_mode,
   output logic                dma_req,
   output logic [CNT_W:0]      dma_len,
   output logic                dma_to_dev,
   output logic                cmd_capture,
   output logic                cmd_issue,
   output logic                sel_go,
   output logic                sel_atn,
   output logic [ID_W-1:0]     sel_tgt,
   output logic                chip_rst,
   output logic                bus_rst,
   output logic                bad_op
);

   localparam int NBYTES = CNT_W / 8;

   if (ID_W < 1 || ID_W > 4) begin : g_bad_id
      $error("xfer_cmd_decoder: ID_W must be 1..4");
   end
   if (CMD_ADDR == ID_ADDR || CMD_ADDR < NBYTES || ID_ADDR < NBYTES) begin : g_bad_map
      $error("xfer_cmd_decoder: register indices overlap");
   end
   if (CMD_ADDR >= 2**ADDR_W || ID_ADDR >= 2**ADDR_W) begin : g_bad_addr
      $error("xfer_cmd_decoder: register index beyond ADDR_W");
   end

   logic       cmd_wr, id_wr, dmab;
   logic [6:0] op;

   assign cmd_wr = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
   assign id_wr  = wr_en && (wr_addr == ADDR_W'(ID_ADDR));
   assign dmab   = wr_data[7];
   assign op     = wr_data[6:0];

   logic wipe, sel_req;
   sel_e req_kind;

   assign wipe     = cmd_wr && (op == OP_CHIPRST);
   assign req_kind = sel_kind(op);
   assign sel_req  = cmd_wr && (req_kind != SEL_NONE);

   logic [ID_W-1:0] busid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busid_q <= '0;
      else if (wipe)  busid_q <= '0;
      else if (id_wr) busid_q <= wr_data[ID_W-1:0];
   end

   logic           cnt_hit, drain;
   logic [CNT_W:0] len;

   assign drain = dma_done && !cmd_capture;

   cdx_xfer_count #(
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .CMD_LIMIT (CMD_LIMIT),
      .ZERO_FULL (ZERO_FULL)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .reload  (cmd_wr && dmab),
      .wipe    (wipe),
      .drain   (drain),
      .capture (cmd_capture),
      .rem     (xfer_rem),
      .cnt_q   (count_q),
      .len     (len),
      .hit     (cnt_hit)
   );

   logic sel_fire;
   sel_e fire_kind;

   cdx_sel_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (sel_req),
      .req_kind  (req_kind),
      .dma_en    (dma_en),
      .wipe      (wipe),
      .fire      (sel_fire),
      .fire_kind (fire_kind)
   );

   logic tgt_ok;
   assign tgt_ok = tgt_present[busid_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q    <= '0;
         cause_q     <= '0;
         seq_q       <= '0;
         flags_q     <= '0;
         irq_set     <= 1'b0;
         dma_mode    <= 1'b0;
         dma_req     <= 1'b0;
         dma_len     <= '0;
         dma_to_dev  <= 1'b0;
         cmd_capture <= 1'b0;
         cmd_issue   <= 1'b0;
         sel_go      <= 1'b0;
         sel_atn     <= 1'b0;
         sel_tgt     <= '0;
         chip_rst    <= 1'b0;
         bus_rst     <= 1'b0;
         bad_op      <= 1'b0;
      end else if (wipe) begin
         status_q    <= '0;
         cause_q     <= '0;
         seq_q       <= '0;
         flags_q     <= '0;
         irq_set     <= 1'b0;
         dma_mode    <= 1'b0;
         dma_req     <= 1'b0;
         dma_len     <= '0;
         dma_to_dev  <= 1'b0;
         cmd_capture <= 1'b0;
         cmd_issue   <= 1'b0;
         sel_go      <= 1'b0;
         sel_atn     <= 1'b0;
         sel_tgt     <= '0;
         chip_rst    <= 1'b1;
         bus_rst     <= 1'b0;
         bad_op      <= 1'b0;
      end else begin
         irq_set   <= 1'b0;
         dma_req   <= 1'b0;
         cmd_issue <= 1'b0;
         sel_go    <= 1'b0;
         chip_rst  <= 1'b0;
         bus_rst   <= 1'b0;
         bad_op    <= 1'b0;

         if (cnt_hit) status_q[4] <= 1'b0;

         if (cmd_wr) begin
            dma_mode <= dmab;
            case (op)
               OP_FLUSH: begin
                  cause_q <= CA_FC;
                  seq_q   <= '0;
                  flags_q <= '0;
               end
               OP_BUSRST: begin
                  cause_q <= CA_BRST;
                  bus_rst <= 1'b1;
                  irq_set <= !busrst_quiet;
               end
               OP_XFER: begin
                  if (dmab) begin
                     status_q[4] <= 1'b0;
                     if (len != '0) begin
                        dma_req    <= 1'b1;
                        dma_len    <= len;
                        dma_to_dev <= cmd_capture ? 1'b1 : xfer_out;
                     end
                  end else if (cmd_capture) begin
                     cmd_capture <= 1'b0;
                     cmd_issue   <= 1'b1;
                  end
               end
               OP_CMPLT: begin
                  cause_q <= CA_FC;
                  irq_set <= 1'b1;
                  if (dmab) begin
                     status_q <= ST_TC | ST_STSPH | ST_MSGIN;
                     seq_q    <= SEQ_CMD;
                  end else begin
                     status_q <= status_q | ST_MSGIN;
                     flags_q  <= 5'd2;
                  end
               end
               OP_MSGOK: begin
                  cause_q <= CA_DC;
                  seq_q   <= '0;
                  flags_q <= '0;
                  irq_set <= 1'b1;
               end
               OP_PAD: begin
                  status_q <= ST_TC;
                  cause_q  <= CA_FC;
                  seq_q    <= '0;
               end
               OP_ARM: cause_q <= '0;
               OP_NOP, OP_ATN, OP_SEL, OP_SELA, OP_SELAS: ;
               default: bad_op <= 1'b1;
            endcase
         end

         if (sel_fire) begin
            if (!tgt_ok) begin
               status_q <= '0;
               cause_q  <= CA_DC;
               seq_q    <= '0;
               irq_set  <= 1'b1;
            end else if (fire_kind == SEL_STOP) begin
               cmd_capture <= 1'b1;
               status_q    <= ST_TC | ST_CMDPH;
               cause_q     <= CA_BS | CA_FC;
               seq_q       <= SEQ_CMD;
               irq_set     <= 1'b1;
            end else begin
               sel_go  <= 1'b1;
               sel_atn <= (fire_kind == SEL_ATN);
               sel_tgt <= busid_q;
            end
         end

         if (dma_done) begin
            if (cmd_capture) begin
               cmd_capture <= 1'b0;
               cmd_issue   <= 1'b1;
            end else begin
               status_q[4] <= 1'b1;
               cause_q     <= CA_BS;
               seq_q       <= '0;
               flags_q     <= '0;
               irq_set     <= 1'b1;
            end
         end
      end
   end

   // R3
   req_len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> dma_len != '0);

   // R4
   cap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && cmd_capture) |-> (dma_to_dev && dma_len <= (CNT_W+1)'(CMD_LIMIT)));

   // R2
   byte_wr_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_hit && !dma_done && !sel_fire) |=> !status_q[4]);

   // R5
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done && !cmd_capture && !wr_en && !sel_fire)
         |=> (count_q == '0 && status_q[4] && cause_q == CA_BS && irq_set));

   // R12
   issue_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_issue |-> !cmd_capture);

   // R13
   chip_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst |-> (status_q == '0 && count_q == '0 && !cmd_capture && busid_q == '0));

   // R14
   bad_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !op_known(op) && !dma_done && !sel_fire)
         |=> (bad_op && $stable(status_q) && $stable(cause_q) && $stable(seq_q)
              && $stable(flags_q) && $stable(cmd_capture)));

endmodule

// File: tb/sim_xfer_cmd_decoder.sv
module sim_xfer_cmd_decoder;

   localparam int CNT_W = 8;
   localparam int ID_W  = 3;
   localparam int LIM   = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [3:0]       wr_addr = '0;
   logic [7:0]       wr_data = '0;
   logic             dma_en = 1'b1;
   logic [7:0]       tgt_present = '0;
   logic [CNT_W:0]   xfer_rem = '0;
   logic             xfer_out = 1'b0;
   logic             dma_done = 1'b0;
   logic             busrst_quiet = 1'b0;

   logic [CNT_W-1:0] count_q;
   logic [7:0]       status_q, cause_q;
   logic [2:0]       seq_q;
   logic [4:0]       flags_q;
   logic             irq_set, dma_mode, dma_req, dma_to_dev, cmd_capture, cmd_issue;
   logic [CNT_W:0]   dma_len;
   logic             sel_go, sel_atn, chip_rst, bus_rst, bad_op;
   logic [ID_W-1:0]  sel_tgt;

   xfer_cmd_decoder #(.CNT_W(CNT_W), .ID_W(ID_W), .CMD_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dma_en(dma_en), .tgt_present(tgt_present), .xfer_rem(xfer_rem),
      .xfer_out(xfer_out), .dma_done(dma_done), .busrst_quiet(busrst_quiet),
      .count_q(count_q), .status_q(status_q), .cause_q(cause_q), .seq_q(seq_q),
      .flags_q(flags_q), .irq_set(irq_set), .dma_mode(dma_mode), .dma_req(dma_req),
      .dma_len(dma_len), .dma_to_dev(dma_to_dev), .cmd_capture(cmd_capture),
      .cmd_issue(cmd_issue), .sel_go(sel_go), .sel_atn(sel_atn), .sel_tgt(sel_tgt),
      .chip_rst(chip_rst), .bus_rst(bus_rst), .bad_op(bad_op));

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 4'(a);
      wr_data = 8'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      dma_done = 1'b1;
      @(negedge clk);
      dma_done = 1'b0;
   endtask

   function automatic bit is_def(input int o);
      case (o)
         8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12,
         8'h18, 8'h1A, 8'h41, 8'h42, 8'h43, 8'h44: is_def = 1'b1;
         default: is_def = 1'b0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int s0, c0, q0, f0, k0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R13 values)
      chk("R13 reset status", status_q, 0);
      chk("R13 reset cause", cause_q, 0);
      chk("R13 reset count", count_q, 0);
      chk("R13 reset capture", cmd_capture, 0);

      // R1: byte write alone, non-DMA, DMA reload
      wr(0, 8'h5A);
      chk("R1 no reload on byte write", count_q, 0);
      wr(3, 8'h00);
      chk("R1 non-DMA keeps count", count_q, 0);
      chk("R1 dma flag clear", dma_mode, 0);
      wr(3, 8'h80);
      chk("R1 DMA reload", count_q, 8'h5A);
      chk("R1 dma flag set", dma_mode, 1);

      // R2: byte write clears TC
      wr(3, 8'h18);
      chk("R6 pad status", status_q, 8'h10);
      wr(0, 8'h33);
      chk("R2 tc cleared", status_q, 0);
      chk("R2 count unchanged", count_q, 8'h5A);

      // R3: sweep all counter values against remaining sizes
      for (int c = 0; c < 256; c++) begin
         int eff;
         int rems[6];
         eff = (c == 0) ? 256 : c;
         rems[0] = 0; rems[1] = 1; rems[2] = eff;
         rems[3] = (eff + 1 > 511) ? 511 : eff + 1;
         rems[4] = 300; rems[5] = (eff > 1) ? eff - 1 : 2;
         for (int r = 0; r < 6; r++) begin
            int exp;
            exp = (eff < rems[r]) ? eff : rems[r];
            wr(0, c);
            xfer_rem = 9'(rems[r]);
            xfer_out = 1'(c + r);
            wr(3, 8'h90);
            chk("R3 req", dma_req, (exp != 0) ? 1 : 0);
            if (exp != 0) begin
               chk("R3 len", dma_len, exp);
               chk("R3 dir", dma_to_dev, (c + r) % 2);
            end
            chk("R3 tc clear", status_q[4], 0);
            chk("R1 count reload", count_q, c);
         end
      end
      @(negedge clk);
      chk("R3 single pulse", dma_req, 0);

      // R10: select with ATN and stop on present target
      tgt_present = 8'hA5;
      wr(4, 2);
      wr(3, 8'hC3);
      chk("R10 capture", cmd_capture, 1);
      chk("R10 status", status_q, 8'h12);
      chk("R10 cause", cause_q, 8'h18);
      chk("R10 seq", seq_q, 4);
      chk("R10 irq", irq_set, 1);

      // R4: capture clamp sweep, direction forced to device
      xfer_out = 1'b0;
      xfer_rem = 9'd3;
      for (int c = 0; c < 256; c++) begin
         int eff;
         eff = (c == 0) ? 256 : c;
         wr(0, c);
         wr(3, 8'h90);
         chk("R4 req", dma_req, 1);
         chk("R4 len", dma_len, (eff < LIM) ? eff : LIM);
         chk("R4 dir", dma_to_dev, 1);
         chk("R4 stays capture", cmd_capture, 1);
      end

      // R12: done in capture, then non-DMA transfer in capture
      s0 = status_q;
      done_pulse();
      chk("R12 issue on done", cmd_issue, 1);
      chk("R12 capture left", cmd_capture, 0);
      chk("R12 status kept", status_q, s0);
      wr(3, 8'h43);
      chk("R12 recapture", cmd_capture, 1);
      wr(3, 8'h10);
      chk("R12 issue on ti", cmd_issue, 1);
      chk("R12 capture left ti", cmd_capture, 0);
      chk("R12 status kept ti", status_q, 8'h12);

      // R5: completion outside capture
      wr(0, 8'h40);
      wr(3, 8'h80);
      chk("R5 pre count", count_q, 8'h40);
      done_pulse();
      chk("R5 tc", status_q[4], 1);
      chk("R5 cause", cause_q, 8'h10);
      chk("R5 seq", seq_q, 0);
      chk("R5 flags", flags_q, 0);
      chk("R5 count", count_q, 0);
      chk("R5 irq", irq_set, 1);

      // R8: completion sequence
      wr(3, 8'h91);
      chk("R8 dma status", status_q, 8'h17);
      chk("R8 dma cause", cause_q, 8'h08);
      chk("R8 dma seq", seq_q, 4);
      chk("R8 dma irq", irq_set, 1);
      wr(3, 8'h18);
      wr(3, 8'h11);
      chk("R8 pio status", status_q, 8'h17);
      chk("R8 pio flags", flags_q, 2);
      chk("R8 pio seq", seq_q, 0);
      chk("R8 pio irq", irq_set, 1);

      // R6: flush, enable selection, no-op, set ATN
      wr(3, 8'h01);
      chk("R6 flush cause", cause_q, 8'h08);
      chk("R6 flush flags", flags_q, 0);
      chk("R6 flush seq", seq_q, 0);
      chk("R6 flush irq", irq_set, 0);
      wr(3, 8'h44);
      chk("R6 arm cause", cause_q, 0);
      chk("R6 arm irq", irq_set, 0);
      wr(3, 8'h91);
      s0 = status_q; c0 = cause_q; q0 = seq_q; f0 = flags_q; k0 = count_q;
      wr(3, 8'h00);
      wr(3, 8'h1A);
      chk("R6 nop status", status_q, s0);
      chk("R6 nop cause", cause_q, c0);
      chk("R6 nop seq", seq_q, q0);
      chk("R6 nop flags", flags_q, f0);
      chk("R6 nop count", count_q, k0);
      chk("R6 nop irq", irq_set, 0);

      // R7: message accepted, bus reset
      wr(3, 8'h12);
      chk("R7 msg cause", cause_q, 8'h20);
      chk("R7 msg seq", seq_q, 0);
      chk("R7 msg irq", irq_set, 1);
      busrst_quiet = 1'b0;
      wr(3, 8'h03);
      chk("R7 busrst cause", cause_q, 8'h80);
      chk("R7 busrst pulse", bus_rst, 1);
      chk("R7 busrst irq", irq_set, 1);
      busrst_quiet = 1'b1;
      wr(3, 8'h03);
      chk("R7 quiet irq", irq_set, 0);
      busrst_quiet = 1'b0;

      // R9: all targets against presence mask
      for (int t = 0; t < 8; t++) begin
         bit pres;
         pres = tgt_present[t];
         wr(4, 8'hF8 | t);
         wr(3, 8'h42);
         chk("R9 go", sel_go, pres ? 1 : 0);
         if (pres) begin
            chk("R9 tgt", sel_tgt, t);
            chk("R9 atn", sel_atn, 1);
         end else begin
            chk("R9 absent status", status_q, 0);
            chk("R9 absent cause", cause_q, 8'h20);
            chk("R9 absent seq", seq_q, 0);
            chk("R9 absent irq", irq_set, 1);
         end
      end
      wr(4, 0);
      wr(3, 8'h41);
      chk("R9 plain go", sel_go, 1);
      chk("R9 plain atn", sel_atn, 0);

      // R11: held while enable low, runs on rise with current ID
      @(negedge clk);
      dma_en = 1'b0;
      wr(4, 2);
      wr(3, 8'h42);
      chk("R11 held", sel_go, 0);
      wr(4, 7);
      repeat (3) @(negedge clk);
      chk("R11 still held", sel_go, 0);
      dma_en = 1'b1;
      @(negedge clk);
      chk("R11 fired", sel_go, 1);
      chk("R11 tgt at rise", sel_tgt, 7);
      @(negedge clk);
      chk("R11 once", sel_go, 0);

      // R14: every undefined opcode
      wr(3, 8'h18);
      for (int o = 0; o < 128; o++) begin
         if (!is_def(o)) begin
            s0 = status_q; c0 = cause_q; q0 = seq_q; f0 = flags_q; k0 = count_q;
            wr(3, o);
            chk("R14 flag", bad_op, 1);
            chk("R14 status", status_q, s0);
            chk("R14 cause", cause_q, c0);
            chk("R14 seq", seq_q, q0);
            chk("R14 flags", flags_q, f0);
            chk("R14 count", count_q, k0);
            chk("R14 irq", irq_set, 0);
         end
      end

      // R13: chip reset
      wr(0, 8'h77);
      wr(3, 8'hC3);
      chk("R13 pre capture", cmd_capture, 1);
      wr(3, 8'h02);
      chk("R13 pulse", chip_rst, 1);
      chk("R13 status", status_q, 0);
      chk("R13 cause", cause_q, 0);
      chk("R13 count", count_q, 0);
      chk("R13 capture", cmd_capture, 0);
      wr(3, 8'h80);
      chk("R13 written bytes wiped", count_q, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule